// File: doc/BRIEF.md
# Cyclic Prefix Framer for a Multicarrier Modem

This block sits on both sides of the transform in a multicarrier modem and handles the guard interval. On the transmit side it paces symbol bursts with a frame timer. At each frame tick it walks the read port of a 64-entry time-domain sample RAM. It first replays the tail of the stored symbol as a prefix and then streams the whole symbol. Samples come out one per clock, with a flag that marks the prefix part.

On the receive side it accepts a serial sample stream whose first sample of each symbol is marked. It drops the prefix samples and writes the remaining samples into a 128-entry buffer split into two halves. After the last sample of a symbol has been written, it swaps halves and issues a one-cycle ready pulse that names the half just filled. The transform can then read that half while the other one is filling.

Top module: `cp_framer`

## Requirements
- R1: While reset is asserted, txValid, txRdEn, rxWrEn and rxFrameReady are 0 and rxFillHalf is 0.
- R2: Each transmit burst has PREFIX_LEN+64 samples on consecutive cycles. These are RAM entries 64-PREFIX_LEN..63 followed by 0..63. txPrefix is 1 for exactly the first PREFIX_LEN samples of the burst.
- R3: The first sample of the first burst appears on the third rising edge after txEnable is first sampled high. While txEnable stays high, bursts start every FRAME_CLKS (default 217) cycles.
- R4: While txEnable is low no new burst starts, and a burst already under way completes.
- R5: The first PREFIX_LEN accepted samples of a receive frame are never written. The frame is counted from the sample taken with rxSof=1.
- R6: The accepted sample at frame position k, for PREFIX_LEN <= k < PREFIX_LEN+64, is written one cycle after it is taken. The write address is rxFillHalf*64 + (k-PREFIX_LEN): bit 6 selects the half and bits 5..0 give the position.
- R7: The write of the 64th payload sample is accompanied by a one-cycle rxFrameReady pulse, with rxReadyHalf equal to the half just filled. rxFillHalf toggles on the same edge and changes at no other time.
- R8: Samples that arrive before the first rxSof after reset are not written. The same holds for samples after the 64th payload sample and before the next rxSof.
- R9: An rxSof in the middle of a frame restarts counting at position 0 in the same half, without a toggle or a ready pulse.
- R10: Cycles with rxValid low are ignored, including their rxSof and rxSample, and do not advance the frame position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Runs the frame timer and allows bursts |
| txRdEn | output | 1 | Read enable to the transmit sample RAM |
| txRdAddr | output | 6 | Read address to the transmit sample RAM |
| txRdData | input | 12 | Read data, valid one cycle after txRdEn |
| txValid | output | 1 | Outgoing sample valid |
| txPrefix | output | 1 | Outgoing sample belongs to the prefix |
| txSample | output | 12 | Outgoing sample |
| rxValid | input | 1 | Incoming sample valid |
| rxSof | input | 1 | Incoming sample is the first of a frame |
| rxSample | input | 12 | Incoming sample |
| rxWrEn | output | 1 | Write enable to the receive buffer |
| rxWrAddr | output | 7 | Write address (half bit on top) |
| rxWrData | output | 12 | Write data |
| rxFrameReady | output | 1 | One-cycle pulse: a half is full |
| rxReadyHalf | output | 1 | Half that has just been filled |
| rxFillHalf | output | 1 | Half currently being filled |

## Verification
The embedded properties assume the frame period is longer than one burst. They also assume the transmit RAM returns data exactly one cycle after a read. The bench keeps FRAME_CLKS at 217 against an 80-sample burst, models the RAM with that latency, and never pulses txEnable while a burst is running. Receive stimulus mixes random gaps, which carry random rxSof and data values, with random trailing samples and random restarts. It also includes directed cases for garbage before the first frame, an exact frame, a trailing run and a mid-frame restart. A scoreboard computes the expected writes and ready pulses from the requirements.

// File: rtl/cp_framer_pkg.sv
package cp_framer_pkg;

  // One-bit strobes passed from the sequencer to the datapath
  typedef struct packed {
    logic txRead;    // read the transmit RAM this cycle
    logic txPrefix;  // current read belongs to the prefix
    logic rxWrite;   // current receive sample is payload
    logic rxLast;    // current receive sample completes the frame
    logic rxHalf;    // half being filled
  } cpStrobes_t;

endpackage

// File: rtl/cp_framer_ctrl.sv
module cp_framer_ctrl
  import cp_framer_pkg::*;
#(
  parameter int LOG2_LEN   = 6,
  parameter int PREFIX_LEN = 16,
  parameter int FRAME_CLKS = 217
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txEnable,
  input  logic                rxValid,
  input  logic                rxSof,
  output cpStrobes_t          strb,
  output logic [LOG2_LEN-1:0] txPosLow,
  output logic [LOG2_LEN-1:0] rxIdxLow,
  output logic                rxFillHalf
);

  localparam int FRAME_LEN = 1 << LOG2_LEN;
  localparam int BURST     = PREFIX_LEN + FRAME_LEN;
  localparam int CNT_W     = $clog2(BURST + 1);
  localparam int TMR_W     = $clog2(FRAME_CLKS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(BURST - 1);
  localparam logic [CNT_W-1:0] PRE_CNT  = CNT_W'(PREFIX_LEN);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(BURST);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(FRAME_CLKS - 1);

  logic [TMR_W-1:0] frameCnt;
  logic             tick;
  logic             txActive;
  logic [CNT_W-1:0] txPos;
  logic [CNT_W-1:0] rxIdx;
  logic [CNT_W-1:0] idxNow;
  logic             rxTake;

  // Frame timer: ticks at count zero while enabled
  assign tick = txEnable && (frameCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN || !txEnable) begin
      frameCnt <= '0;
    end else if (frameCnt == TMR_LAST) begin
      frameCnt <= '0;
    end else begin
      frameCnt <= frameCnt + 1'b1;
    end
  end

  // Transmit burst sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txActive <= 1'b0;
      txPos    <= '0;
    end else if (!txActive) begin
      if (tick) begin
        txActive <= 1'b1;
        txPos    <= '0;
      end
    end else if (txPos == LAST_POS) begin
      txActive <= 1'b0;
    end else begin
      txPos <= txPos + 1'b1;
    end
  end

  // Receive frame position
  always_comb begin
    idxNow        = rxSof ? '0 : rxIdx;
    rxTake        = rxValid && (idxNow < DONE_CNT);
    strb.txRead   = txActive;
    strb.txPrefix = txActive && (txPos < PRE_CNT);
    strb.rxWrite  = rxTake && (idxNow >= PRE_CNT);
    strb.rxLast   = rxTake && (idxNow == LAST_POS);
    strb.rxHalf   = rxFillHalf;
  end

  assign txPosLow = txPos[LOG2_LEN-1:0];
  assign rxIdxLow = idxNow[LOG2_LEN-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxIdx      <= DONE_CNT;
      rxFillHalf <= 1'b0;
    end else begin
      if (rxTake) begin
        rxIdx <= idxNow + 1'b1;
      end
      if (strb.rxLast) begin
        rxFillHalf <= ~rxFillHalf;
      end
    end
  end

  // R2
  burst_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && txPos != LAST_POS) |=> (txActive && txPos == $past(txPos) + 1'b1));

  // R2
  burst_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && txPos == LAST_POS) |=> !txActive);

  // R9
  sof_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxSof) |=> (rxIdx == CNT_W'(1)));

  // R7
  half_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rxLast |=> $stable(rxFillHalf));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(rxIdx));

endmodule

// File: rtl/cp_framer_dpath.sv
module cp_framer_dpath
  import cp_framer_pkg::*;
#(
  parameter int LOG2_LEN   = 6,
  parameter int PREFIX_LEN = 16,
  parameter int SAMPLE_W   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  cpStrobes_t          strb,
  input  logic [LOG2_LEN-1:0] txPosLow,
  input  logic [LOG2_LEN-1:0] rxIdxLow,
  output logic                txRdEn,
  output logic [LOG2_LEN-1:0] txRdAddr,
  input  logic [SAMPLE_W-1:0] txRdData,
  output logic                txValid,
  output logic                txPrefix,
  output logic [SAMPLE_W-1:0] txSample,
  input  logic [SAMPLE_W-1:0] rxSample,
  output logic                rxWrEn,
  output logic [LOG2_LEN:0]   rxWrAddr,
  output logic [SAMPLE_W-1:0] rxWrData,
  output logic                rxFrameReady,
  output logic                rxReadyHalf
);

  localparam int FRAME_LEN = 1 << LOG2_LEN;
  // Modulo the frame length, both prefix and body addresses are pos - prefix
  localparam logic [LOG2_LEN-1:0] TX_OFFS = LOG2_LEN'(FRAME_LEN - PREFIX_LEN);
  localparam logic [LOG2_LEN-1:0] RX_OFFS = LOG2_LEN'(PREFIX_LEN);

  logic pendValid;
  logic pendPrefix;

  assign txRdEn   = strb.txRead;
  assign txRdAddr = txPosLow + TX_OFFS;

  // Two stages: RAM latency, then output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid  <= 1'b0;
      pendPrefix <= 1'b0;
      txValid    <= 1'b0;
      txPrefix   <= 1'b0;
      txSample   <= '0;
    end else begin
      pendValid  <= strb.txRead;
      pendPrefix <= strb.txPrefix;
      txValid    <= pendValid;
      txPrefix   <= pendPrefix;
      if (pendValid) begin
        txSample <= txRdData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxWrEn       <= 1'b0;
      rxWrAddr     <= '0;
      rxWrData     <= '0;
      rxFrameReady <= 1'b0;
      rxReadyHalf  <= 1'b0;
    end else begin
      rxWrEn       <= strb.rxWrite;
      rxFrameReady <= strb.rxLast;
      if (strb.rxWrite) begin
        rxWrAddr <= {strb.rxHalf, rxIdxLow - RX_OFFS};
        rxWrData <= rxSample;
      end
      if (strb.rxLast) begin
        rxReadyHalf <= strb.rxHalf;
      end
    end
  end

  // R7
  ready_last_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxFrameReady |-> (rxWrEn && rxWrAddr == {rxReadyHalf, {LOG2_LEN{1'b1}}}));

  // R2
  tx_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(txRdEn, 2));

endmodule

// File: rtl/cp_framer.sv
module cp_framer
  import cp_framer_pkg::*;
#(
  parameter int LOG2_LEN   = 6,
  parameter int PREFIX_LEN = 16,
  parameter int SAMPLE_W   = 12,
  parameter int FRAME_CLKS = 217
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txEnable,
  output logic                txRdEn,
  output logic [LOG2_LEN-1:0] txRdAddr,
  input  logic [SAMPLE_W-1:0] txRdData,
  output logic                txValid,
  output logic                txPrefix,
  output logic [SAMPLE_W-1:0] txSample,
  input  logic                rxValid,
  input  logic                rxSof,
  input  logic [SAMPLE_W-1:0] rxSample,
  output logic                rxWrEn,
  output logic [LOG2_LEN:0]   rxWrAddr,
  output logic [SAMPLE_W-1:0] rxWrData,
  output logic                rxFrameReady,
  output logic                rxReadyHalf,
  output logic                rxFillHalf
);

  cpStrobes_t          strb;
  logic [LOG2_LEN-1:0] txPosLow;
  logic [LOG2_LEN-1:0] rxIdxLow;

  cp_framer_ctrl #(
    .LOG2_LEN  (LOG2_LEN),
    .PREFIX_LEN(PREFIX_LEN),
    .FRAME_CLKS(FRAME_CLKS)
  ) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txEnable  (txEnable),
    .rxValid   (rxValid),
    .rxSof     (rxSof),
    .strb      (strb),
    .txPosLow  (txPosLow),
    .rxIdxLow  (rxIdxLow),
    .rxFillHalf(rxFillHalf)
  );

  cp_framer_dpath #(
    .LOG2_LEN  (LOG2_LEN),
    .PREFIX_LEN(PREFIX_LEN),
    .SAMPLE_W  (SAMPLE_W)
  ) dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .txPosLow    (txPosLow),
    .rxIdxLow    (rxIdxLow),
    .txRdEn      (txRdEn),
    .txRdAddr    (txRdAddr),
    .txRdData    (txRdData),
    .txValid     (txValid),
    .txPrefix    (txPrefix),
    .txSample    (txSample),
    .rxSample    (rxSample),
    .rxWrEn      (rxWrEn),
    .rxWrAddr    (rxWrAddr),
    .rxWrData    (rxWrData),
    .rxFrameReady(rxFrameReady),
    .rxReadyHalf (rxReadyHalf)
  );

  // R10
  write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxWrEn |-> $past(rxValid));

  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxFrameReady |=> !rxFrameReady);

endmodule

// File: tb/cp_framer_test.sv
`timescale 1ns / 100ps
module cp_framer_test;

  localparam int LOG2_LEN = 6;
  localparam int N        = 64;
  localparam int CP       = 16;
  localparam int SW       = 12;
  localparam int FCLKS    = 217;
  localparam int BURST    = CP + N;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          txEnable = 1'b0;
  logic          txRdEn;
  logic [5:0]    txRdAddr;
  logic [SW-1:0] txRdData = '0;
  logic          txValid, txPrefix;
  logic [SW-1:0] txSample;
  logic          rxValid = 1'b0, rxSof = 1'b0;
  logic [SW-1:0] rxSample = '0;
  logic          rxWrEn;
  logic [6:0]    rxWrAddr;
  logic [SW-1:0] rxWrData;
  logic          rxFrameReady, rxReadyHalf, rxFillHalf;

  always #2 clk = ~clk;

  cp_framer #(.LOG2_LEN(LOG2_LEN), .PREFIX_LEN(CP), .SAMPLE_W(SW), .FRAME_CLKS(FCLKS)) uut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .txRdEn(txRdEn), .txRdAddr(txRdAddr),
    .txRdData(txRdData), .txValid(txValid), .txPrefix(txPrefix), .txSample(txSample),
    .rxValid(rxValid), .rxSof(rxSof), .rxSample(rxSample), .rxWrEn(rxWrEn),
    .rxWrAddr(rxWrAddr), .rxWrData(rxWrData), .rxFrameReady(rxFrameReady),
    .rxReadyHalf(rxReadyHalf), .rxFillHalf(rxFillHalf)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [SW-1:0] txMem [N];

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (txRdEn) txRdData <= txMem[txRdAddr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int txExpected(input int idx);
    return (idx < CP) ? int'(txMem[N - CP + idx]) : int'(txMem[idx - CP]);
  endfunction

  // transmit monitor state
  int  txIdx = 0, startCount = 0, burstsDone = 0, lastStart = -1, enCyc = 0;
  bit  periodCheck = 0, firstPending = 0;

  // receive scoreboard
  int wqAddr[$], wqData[$], wqCyc[$], rqHalf[$], rqCyc[$];
  int mIdx = BURST;
  int mHalf = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (txValid) begin
        if (txIdx == 0) begin
          startCount++;
          if (firstPending) begin
            check(cyc == enCyc + 3, "R3 first burst latency", cyc - enCyc, 3);
            firstPending = 0;
          end else if (periodCheck && lastStart >= 0) begin
            check(cyc - lastStart == FCLKS, "R3 burst period", cyc - lastStart, FCLKS);
          end
          lastStart = cyc;
        end
        check(int'(txSample) == txExpected(txIdx), "R2 sample order", int'(txSample), txExpected(txIdx));
        check(txPrefix == (txIdx < CP), "R2 prefix flag", int'(txPrefix), int'(txIdx < CP));
        txIdx++;
        if (txIdx == BURST) begin
          txIdx = 0;
          burstsDone++;
        end
      end else if (txIdx != 0) begin
        check(1'b0, "R2 gap inside burst", txIdx, BURST);
        txIdx = 0;
      end

      if (rxWrEn) begin
        if (wqAddr.size() == 0) begin
          check(1'b0, "R5 R8 unexpected write", int'(rxWrAddr), -1);
        end else begin
          int ea, ed, ec;
          ea = wqAddr.pop_front();
          ed = wqData.pop_front();
          ec = wqCyc.pop_front();
          check(int'(rxWrAddr) == ea, "R5 R6 write address", int'(rxWrAddr), ea);
          check(int'(rxWrData) == ed, "R6 write data", int'(rxWrData), ed);
          check(cyc == ec, "R6 write timing", cyc, ec);
        end
      end
      if (rxFrameReady) begin
        if (rqHalf.size() == 0) begin
          check(1'b0, "R7 unexpected ready", int'(rxReadyHalf), -1);
        end else begin
          int eh, ec;
          eh = rqHalf.pop_front();
          ec = rqCyc.pop_front();
          check(int'(rxReadyHalf) == eh, "R7 ready half", int'(rxReadyHalf), eh);
          check(cyc == ec, "R7 ready timing", cyc, ec);
          check(rxFillHalf == ~rxReadyHalf, "R7 fill half toggled", int'(rxFillHalf), int'(~rxReadyHalf));
        end
      end
    end
  end

  task automatic rxPush(input bit v, input bit s, input int d);
    @(posedge clk);
    #1;
    rxValid  = v;
    rxSof    = s;
    rxSample = SW'(d);
    if (v) begin
      int idx;
      idx = s ? 0 : mIdx;
      if (idx < BURST) begin
        if (idx >= CP) begin
          wqAddr.push_back(mHalf * N + idx - CP);
          wqData.push_back(d & ((1 << SW) - 1));
          wqCyc.push_back(cyc + 1);
        end
        if (idx == BURST - 1) begin
          rqHalf.push_back(mHalf);
          rqCyc.push_back(cyc + 1);
          mHalf ^= 1;
        end
        mIdx = idx + 1;
      end
    end
  endtask

  task automatic sendRun(input int len, input int gapPct);
    for (int i = 0; i < len; i++) begin
      while (int'($urandom % 100) < gapPct) rxPush(1'b0, 1'($urandom), int'($urandom));
      rxPush(1'b1, i == 0, int'($urandom));
    end
  endtask

  task automatic settle(input string req);
    rxPush(1'b0, 1'b0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wqAddr.size() == 0 && rqHalf.size() == 0, req, wqAddr.size() + rqHalf.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R2 watchdog expired act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sb, sd;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) txMem[i] = SW'($urandom);

    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      check(!txValid && !txRdEn, "R1 tx idle in reset", int'(txValid), 0);
      check(!rxWrEn && !rxFrameReady, "R1 rx idle in reset", int'(rxWrEn), 0);
      check(!rxFillHalf, "R1 fill half in reset", int'(rxFillHalf), 0);
    end
    @(posedge clk);
    #1 rstN = 1'b1;

    // transmit: latency, order, period
    @(posedge clk);
    #1;
    txEnable = 1'b1;
    enCyc = cyc;
    firstPending = 1;
    periodCheck = 1;
    while (startCount < 4) @(negedge clk);
    repeat (40) @(posedge clk);
    #1 txEnable = 1'b0;
    sb = startCount;
    repeat (600) @(posedge clk);
    @(negedge clk);
    check(burstsDone == sb, "R4 running burst completes", burstsDone, sb);
    check(startCount == sb, "R4 no burst while disabled", startCount, sb);
    check(!txRdEn, "R4 reads stopped", int'(txRdEn), 0);

    // receive: garbage before the first frame marker
    for (int i = 0; i < 20; i++) rxPush(1'b1, 1'b0, int'($urandom));
    settle("R8 no write before first frame");

    // exact frame, no gaps
    sendRun(BURST, 0);
    settle("R6 exact frame written");

    // trailing samples after a full frame
    sendRun(BURST + 10, 0);
    settle("R8 trailing samples ignored");

    // restart in the middle of a frame
    sendRun(30, 0);
    sendRun(BURST, 0);
    settle("R9 mid-frame restart");

    // heavy gaps with random frame markers on idle cycles
    sendRun(BURST, 40);
    settle("R10 idle cycles ignored");

    // random mix
    for (int f = 0; f < 25; f++) begin
      if ($urandom % 5 == 0) sendRun(1 + int'($urandom % (BURST - 1)), 20);
      sd = BURST + int'($urandom % 6);
      sendRun(sd, int'($urandom % 30));
    end
    settle("R6 random frames drained");
    check(mHalf == int'(rxFillHalf), "R7 final fill half", int'(rxFillHalf), mHalf);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule